// File: doc/BRIEF.md
# PCI Command and Status Register Pair

This block keeps the 16-bit command word and the 16-bit status word that sit together in one 32-bit dword of a PCI function's configuration header. A configuration decoder drives write and read strobes, a select line for this dword, four byte enables and write data. The block returns the dword as status in bits 31:16 and command in bits 15:0, one clock after a selected read.

The command word is turned into individual enable outputs that the bus engines use: I/O decode, memory decode, mastering, parity reaction, system-error drive and the rest. When every command bit is zero, an offline flag tells the engines to answer nothing but configuration cycles.

The bus engines report events as single-cycle pulses. Each pulse latches a sticky status bit. Software clears a sticky bit by writing a one to it. Writing a zero leaves the bit alone. The capability and timing fields of the status word are fixed by parameters and cannot be written.

Top module: `pci_cmdstat_regs`

## Requirements
- R1: A selected write with byte enables 0 and 1 set loads command bits 9:0 from write data bits 9:0. Bit 0 drives `en_io`, 1 `en_mem`, 2 `en_master`, 3 `en_special`, 4 `en_mwi`, 5 `en_snoop`, 6 `en_par_resp`, 7 `en_wait`, 8 `en_serr` and 9 `en_fb2b`. Command bits 15:10 always read as zero.
- R2: Byte enable 0 gates command bits 7:0 and byte enable 1 gates command bits 15:8. A byte whose enable is low keeps its contents.
- R3: While `rst_n` is low at a clock edge, the command word, every sticky status bit and the read data are all cleared to zero.
- R4: While the command word is 0000h, `fn_offline` is 1 and every enable output is 0. Otherwise `fn_offline` is 0.
- R5: Each event pulse sets its sticky status bit on the next edge: `ev_tgt_abort_sig` sets bit 11, `ev_tgt_abort_rcv` sets bit 12, `ev_mst_abort_rcv` sets bit 13 and `ev_serr_sig` sets bit 14. `ev_par_err` sets bit 15 whatever command bit 6 holds.
- R6: Status bit 8 is set only by an `ev_par_err` pulse that arrives while `is_master` is 1 and command bit 6 is 1.
- R7: A selected write with byte enable 3 set clears each sticky status bit (8, 11 to 15) whose write data bit (bit + 16) is 1. A data bit of 0 leaves the status bit unchanged.
- R8: If an event and a clearing write reach the same status bit in the same cycle, the bit ends up set.
- R9: Status bits 0 to 3 and 6 read as zero. Bit 4 reads `CAP_LIST`, bit 5 reads `CAP_66MHZ`, bit 7 reads `FB2B_CAP` and bits 10:9 read `DEVSEL_CODE`. Writes do not change any of these bits.
- R10: A read with `cfg_rd` and `cfg_sel` both high returns {status, command} on `cfg_rdata` after the next edge. A write with `cfg_sel` low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low bus reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_sel | input | 1 | This dword is addressed |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data: status in bits 31:16, command in bits 15:0 |
| is_master | input | 1 | The function owns the current transfer as master |
| ev_par_err | input | 1 | Pulse: data parity error seen |
| ev_tgt_abort_sig | input | 1 | Pulse: this function signalled target abort |
| ev_tgt_abort_rcv | input | 1 | Pulse: target abort received as master |
| ev_mst_abort_rcv | input | 1 | Pulse: master abort received |
| ev_serr_sig | input | 1 | Pulse: system error signalled |
| en_io | output | 1 | I/O space decode enable |
| en_mem | output | 1 | Memory space decode enable |
| en_master | output | 1 | Bus mastering enable |
| en_special | output | 1 | Special cycle response enable |
| en_mwi | output | 1 | Memory write and invalidate enable |
| en_snoop | output | 1 | Palette snoop enable |
| en_par_resp | output | 1 | Parity error response enable |
| en_wait | output | 1 | Wait cycle control |
| en_serr | output | 1 | System error drive enable |
| en_fb2b | output | 1 | Fast back-to-back enable |
| fn_offline | output | 1 | Command is zero; only configuration cycles are answered |

## Verification
The bench builds the block with `CAP_LIST=1`, `CAP_66MHZ=1`, `FB2B_CAP=0` and `DEVSEL_CODE=2'b10`. This gives the read-only field the value 0430h. That value differs from every sticky bit and from all-zero, so a write that wrongly reaches a fixed field shows up as a changed read word. The mix of set and clear fixed bits also catches a bit-position error in the constant field. Writing ones into the timing-code positions while clearing sticky bits checks that the clear mask stays off the fixed bits.

// File: rtl/pci_cs_pkg.sv
// Package: bit positions and widths shared by the command/status register pair.
// Assumes a 32-bit configuration dword with command in the low half.
package pci_cs_pkg;
    localparam int HALF_W   = 16;
    localparam int DWORD_W  = 32;
    localparam int BE_W     = DWORD_W / 8;

    // command bit positions (decoded by the bus engines)
    localparam int C_IO      = 0;
    localparam int C_MEM     = 1;
    localparam int C_MASTER  = 2;
    localparam int C_SPECIAL = 3;
    localparam int C_MWI     = 4;
    localparam int C_SNOOP   = 5;
    localparam int C_PARRESP = 6;
    localparam int C_WAIT    = 7;
    localparam int C_SERR    = 8;
    localparam int C_FB2B    = 9;
    localparam int CMD_IMPL  = 10;

    // status bit positions
    localparam int S_CAPLIST = 4;
    localparam int S_66MHZ   = 5;
    localparam int S_FB2B    = 7;
    localparam int S_DPD     = 8;
    localparam int S_DEVSEL  = 9;
    localparam int S_STA     = 11;
    localparam int S_RTA     = 12;
    localparam int S_RMA     = 13;
    localparam int S_SSE     = 14;
    localparam int S_DPE     = 15;

    // sticky (write-one-to-clear) bits of the status word
    localparam logic [HALF_W-1:0] STICKY_MASK = 16'hF900;
endpackage

// File: rtl/pci_cs_cmd_reg.sv
// Command register: byte-gated writable store of the implemented command bits.
// Assumes wr_hit is a single-cycle qualified write; reserved bits stay zero.
module pci_cs_cmd_reg
    import pci_cs_pkg::*;
#(
    parameter int W    = HALF_W,
    parameter int IMPL = CMD_IMPL,
    localparam int NB  = W / 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_hit,
    input  logic [NB-1:0] be,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  cmd_word
);
    localparam logic [W-1:0] IMPL_MASK = W'((1 << IMPL) - 1);

    logic [W-1:0] cmd_q;
    logic [W-1:0] cmd_d;

    // merge enabled write bytes over the held value
    always_comb begin
        cmd_d = cmd_q;
        for (int b = 0; b < NB; b++) begin
            if (wr_hit && be[b]) cmd_d[b*8 +: 8] = wdata[b*8 +: 8];
        end
        cmd_d = cmd_d & IMPL_MASK;
    end

    // store command, cleared by bus reset
    always_ff @(posedge clk) begin
        if (!rst_n) cmd_q <= '0;
        else        cmd_q <= cmd_d;
    end

    assign cmd_word = cmd_q;

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable(cmd_q));
    p_be_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !be[0]) |=> $stable(cmd_q[7:0]));
    p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> (cmd_q[W-1:IMPL] == '0));
endmodule

// File: rtl/pci_cs_status_reg.sv
// Status register: sticky event bits (set by hardware, cleared by writing one)
// combined with parameter-fixed read-only fields. Event set wins over clear.
module pci_cs_status_reg
    import pci_cs_pkg::*;
#(
    parameter int          W           = HALF_W,
    parameter bit          CAP_LIST    = 1'b0,
    parameter bit          CAP_66MHZ   = 1'b0,
    parameter bit          FB2B_CAP    = 1'b0,
    parameter logic [1:0]  DEVSEL_CODE = 2'b01,
    localparam int NB = W / 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_hit,
    input  logic [NB-1:0] be,
    input  logic [W-1:0]  wdata,
    input  logic          par_resp,
    input  logic          is_master,
    input  logic          ev_par_err,
    input  logic          ev_tgt_abort_sig,
    input  logic          ev_tgt_abort_rcv,
    input  logic          ev_mst_abort_rcv,
    input  logic          ev_serr_sig,
    output logic [W-1:0]  status_word
);
    localparam logic [W-1:0] RO_BITS =
        (W'(CAP_LIST)    << S_CAPLIST) |
        (W'(CAP_66MHZ)   << S_66MHZ)   |
        (W'(FB2B_CAP)    << S_FB2B)    |
        (W'(DEVSEL_CODE) << S_DEVSEL);

    logic [W-1:0] sts_q;
    logic [W-1:0] set_v;
    logic [W-1:0] clr_v;

    // event pulses mapped onto sticky bit positions
    always_comb begin
        set_v          = '0;
        set_v[S_DPD]   = ev_par_err && is_master && par_resp;
        set_v[S_STA]   = ev_tgt_abort_sig;
        set_v[S_RTA]   = ev_tgt_abort_rcv;
        set_v[S_RMA]   = ev_mst_abort_rcv;
        set_v[S_SSE]   = ev_serr_sig;
        set_v[S_DPE]   = ev_par_err;
    end

    // write-one-to-clear vector, gated per byte
    always_comb begin
        clr_v = '0;
        for (int b = 0; b < NB; b++) begin
            if (wr_hit && be[b]) clr_v[b*8 +: 8] = wdata[b*8 +: 8];
        end
    end

    // sticky bits: clear first, then set so a coincident event is kept
    always_ff @(posedge clk) begin
        if (!rst_n) sts_q <= '0;
        else        sts_q <= ((sts_q & ~clr_v) | set_v) & STICKY_MASK;
    end

    assign status_word = sts_q | RO_BITS;

    p_set_rma_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ev_mst_abort_rcv |=> sts_q[S_RMA]);
    p_evwins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ev_tgt_abort_sig |=> sts_q[S_STA]);
    p_dpd_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!(ev_par_err && is_master && par_resp) && !sts_q[S_DPD]) |=> !sts_q[S_DPD]);
    p_clear_dpe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && be[NB-1] && wdata[S_DPE] && !ev_par_err) |=> !sts_q[S_DPE]);
    p_zero_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_q[S_SSE] && !(wr_hit && be[NB-1] && wdata[S_SSE])) |=> sts_q[S_SSE]);
endmodule

// File: rtl/pci_cmdstat_regs.sv
// Top: command/status dword of a PCI configuration header. Decodes the
// command into enables, flags the offline state and registers read data.
// Assumes strobes are single-cycle and synchronous to clk.
module pci_cmdstat_regs
    import pci_cs_pkg::*;
#(
    parameter bit         CAP_LIST    = 1'b0,
    parameter bit         CAP_66MHZ   = 1'b0,
    parameter bit         FB2B_CAP    = 1'b0,
    parameter logic [1:0] DEVSEL_CODE = 2'b01
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr,
    input  logic                cfg_rd,
    input  logic                cfg_sel,
    input  logic [BE_W-1:0]     cfg_be,
    input  logic [DWORD_W-1:0]  cfg_wdata,
    output logic [DWORD_W-1:0]  cfg_rdata,
    input  logic                is_master,
    input  logic                ev_par_err,
    input  logic                ev_tgt_abort_sig,
    input  logic                ev_tgt_abort_rcv,
    input  logic                ev_mst_abort_rcv,
    input  logic                ev_serr_sig,
    output logic                en_io,
    output logic                en_mem,
    output logic                en_master,
    output logic                en_special,
    output logic                en_mwi,
    output logic                en_snoop,
    output logic                en_par_resp,
    output logic                en_wait,
    output logic                en_serr,
    output logic                en_fb2b,
    output logic                fn_offline
);
    localparam int HB = BE_W / 2;

    logic              wr_hit;
    logic              rd_hit;
    logic [HALF_W-1:0] cmd_word;
    logic [HALF_W-1:0] status_word;
    logic [DWORD_W-1:0] rd_q;

    assign wr_hit = cfg_wr && cfg_sel;
    assign rd_hit = cfg_rd && cfg_sel;

    pci_cs_cmd_reg #(.W(HALF_W), .IMPL(CMD_IMPL)) u_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_hit   (wr_hit),
        .be       (cfg_be[HB-1:0]),
        .wdata    (cfg_wdata[HALF_W-1:0]),
        .cmd_word (cmd_word)
    );

    pci_cs_status_reg #(
        .W(HALF_W), .CAP_LIST(CAP_LIST), .CAP_66MHZ(CAP_66MHZ),
        .FB2B_CAP(FB2B_CAP), .DEVSEL_CODE(DEVSEL_CODE)
    ) u_sts (
        .clk              (clk),
        .rst_n            (rst_n),
        .wr_hit           (wr_hit),
        .be               (cfg_be[BE_W-1:HB]),
        .wdata            (cfg_wdata[DWORD_W-1:HALF_W]),
        .par_resp         (cmd_word[C_PARRESP]),
        .is_master        (is_master),
        .ev_par_err       (ev_par_err),
        .ev_tgt_abort_sig (ev_tgt_abort_sig),
        .ev_tgt_abort_rcv (ev_tgt_abort_rcv),
        .ev_mst_abort_rcv (ev_mst_abort_rcv),
        .ev_serr_sig      (ev_serr_sig),
        .status_word      (status_word)
    );

    // capture the dword on a selected read
    always_ff @(posedge clk) begin
        if (!rst_n)      rd_q <= '0;
        else if (rd_hit) rd_q <= {status_word, cmd_word};
    end

    assign cfg_rdata = rd_q;

    // decoded enables for the bus engines
    assign en_io       = cmd_word[C_IO];
    assign en_mem      = cmd_word[C_MEM];
    assign en_master   = cmd_word[C_MASTER];
    assign en_special  = cmd_word[C_SPECIAL];
    assign en_mwi      = cmd_word[C_MWI];
    assign en_snoop    = cmd_word[C_SNOOP];
    assign en_par_resp = cmd_word[C_PARRESP];
    assign en_wait     = cmd_word[C_WAIT];
    assign en_serr     = cmd_word[C_SERR];
    assign en_fb2b     = cmd_word[C_FB2B];
    assign fn_offline  = (cmd_word == '0);

    p_offline_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fn_offline |-> !(en_io || en_mem || en_master || en_serr || en_par_resp));
    p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_hit |=> $stable(cfg_rdata));
    p_nosel_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !cfg_sel) |=> $stable(cmd_word));
endmodule

// File: tb/pci_cmdstat_regs_bench.sv
// Scoreboard bench: driver tasks queue expected read words, a monitor pops
// and compares them the cycle the read data appears.
module pci_cmdstat_regs_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0, cfg_rd = 1'b0, cfg_sel = 1'b0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        is_master = 1'b0;
    logic        ev_par_err = 1'b0, ev_tgt_abort_sig = 1'b0, ev_tgt_abort_rcv = 1'b0;
    logic        ev_mst_abort_rcv = 1'b0, ev_serr_sig = 1'b0;
    logic        en_io, en_mem, en_master, en_special, en_mwi, en_snoop;
    logic        en_par_resp, en_wait, en_serr, en_fb2b, fn_offline;

    int errors = 0;
    int checks = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        mon_due = 1'b0;

    localparam logic [31:0] RO_HI = 32'h0430_0000;

    always #2.5 clk = ~clk;

    pci_cmdstat_regs #(
        .CAP_LIST(1'b1), .CAP_66MHZ(1'b1), .FB2B_CAP(1'b0), .DEVSEL_CODE(2'b10)
    ) u_pci_cmdstat_regs (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_sel(cfg_sel),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .is_master(is_master), .ev_par_err(ev_par_err),
        .ev_tgt_abort_sig(ev_tgt_abort_sig), .ev_tgt_abort_rcv(ev_tgt_abort_rcv),
        .ev_mst_abort_rcv(ev_mst_abort_rcv), .ev_serr_sig(ev_serr_sig),
        .en_io(en_io), .en_mem(en_mem), .en_master(en_master), .en_special(en_special),
        .en_mwi(en_mwi), .en_snoop(en_snoop), .en_par_resp(en_par_resp),
        .en_wait(en_wait), .en_serr(en_serr), .en_fb2b(en_fb2b), .fn_offline(fn_offline)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: a read issued before an edge is compared at the following negedge
    always @(posedge clk) mon_due <= rst_n && cfg_rd && cfg_sel;
    always @(negedge clk) begin
        if (mon_due) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R10: actual=%h expected=<none queued>", cfg_rdata);
            end else begin
                check(tag_q.pop_front(), cfg_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic cfg_write(input logic sel, input logic [3:0] be, input logic [31:0] d);
        @(posedge clk); #1;
        cfg_wr = 1'b1; cfg_sel = sel; cfg_be = be; cfg_wdata = d;
        @(posedge clk); #1;
        cfg_wr = 1'b0; cfg_sel = 1'b0; cfg_be = '0; cfg_wdata = '0;
    endtask

    task automatic cfg_read(input logic [31:0] exp, input string tag);
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(posedge clk); #1;
        cfg_rd = 1'b1; cfg_sel = 1'b1;
        @(posedge clk); #1;
        cfg_rd = 1'b0; cfg_sel = 1'b0;
        @(negedge clk); #1;
    endtask

    // pulse events: {par, tgt_sig, tgt_rcv, mst_rcv, serr}
    task automatic pulse(input logic [4:0] ev, input logic master);
        @(posedge clk); #1;
        {ev_par_err, ev_tgt_abort_sig, ev_tgt_abort_rcv, ev_mst_abort_rcv, ev_serr_sig} = ev;
        is_master = master;
        @(posedge clk); #1;
        {ev_par_err, ev_tgt_abort_sig, ev_tgt_abort_rcv, ev_mst_abort_rcv, ev_serr_sig} = '0;
        is_master = 1'b0;
    endtask

    function automatic logic [31:0] en_vec();
        return {21'd0, fn_offline, en_fb2b, en_serr, en_wait, en_par_resp, en_snoop,
                en_mwi, en_special, en_master, en_mem, en_io};
    endfunction

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R3 reset rdata", cfg_rdata, 32'h0);
        check("R4 offline at reset", en_vec(), 32'h400);
        cfg_read(RO_HI, "R3/R9 reset word");

        cfg_write(1'b1, 4'b0011, 32'hFFFF_FFFF);
        @(negedge clk);
        check("R1 all enables", en_vec(), 32'h3FF);
        cfg_read(RO_HI | 32'h03FF, "R1 reserved zero");

        cfg_write(1'b1, 4'b0001, 32'h0);
        cfg_read(RO_HI | 32'h0300, "R2 low byte only");
        cfg_write(1'b1, 4'b0010, 32'h0);
        @(negedge clk);
        check("R4 offline after zero", en_vec(), 32'h400);

        cfg_write(1'b0, 4'b1111, 32'h0000_0007);
        cfg_read(RO_HI, "R10 unselected write ignored");

        pulse(5'b01111, 1'b0);
        cfg_read(32'h7C30_0000, "R5 abort and serr bits");
        pulse(5'b10000, 1'b1);
        cfg_read(32'hFC30_0000, "R5/R6 parity without response");

        cfg_write(1'b1, 4'b0001, 32'h0000_0040);
        pulse(5'b10000, 1'b0);
        cfg_read(32'hFC30_0040, "R6 parity not master");
        pulse(5'b10000, 1'b1);
        cfg_read(32'hFD30_0040, "R6 data parity detected");

        cfg_write(1'b1, 4'b1000, 32'h0);
        cfg_read(32'hFD30_0040, "R7 writing zero keeps");
        cfg_write(1'b1, 4'b0100, 32'h00FF_0000);
        cfg_read(32'hFD30_0040, "R9 low status byte fixed");
        cfg_write(1'b1, 4'b1000, 32'h8E00_0000);
        cfg_read(32'h7530_0040, "R7/R9 clear and devsel fixed");

        // clearing write coincides with master abort event
        @(posedge clk); #1;
        cfg_wr = 1'b1; cfg_sel = 1'b1; cfg_be = 4'b1000; cfg_wdata = 32'h2000_0000;
        ev_mst_abort_rcv = 1'b1;
        @(posedge clk); #1;
        cfg_wr = 1'b0; cfg_sel = 1'b0; cfg_be = '0; cfg_wdata = '0; ev_mst_abort_rcv = 1'b0;
        cfg_read(32'h7530_0040, "R8 set wins");
        cfg_write(1'b1, 4'b1000, 32'h2000_0000);
        cfg_read(32'h5530_0040, "R7 clear single bit");
        cfg_write(1'b1, 4'b1000, 32'hFF00_0000);
        cfg_read(32'h0430_0040, "R7 clear all");

        cfg_write(1'b1, 4'b0011, 32'h0000_0105);
        pulse(5'b11111, 1'b1);
        @(posedge clk); #1 rst_n = 1'b0;
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        check("R3 mid-run reset enables", en_vec(), 32'h400);
        cfg_read(RO_HI, "R3 mid-run reset word");

        repeat (3) @(posedge clk);
        if (exp_q.size() != 0) begin
            checks++; errors++;
            $display("FAIL R10: actual=%0d reads left expected=0", exp_q.size());
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule